// File: doc/BRIEF.md
# USB Pipe Handshake Response Controller

This block keeps the control state of a set of USB endpoint pipes (five by default) and picks the handshake for each transaction. Software reaches each pipe through a 16-bit control word. In that word it can choose the response mode, enable automatic responses, request a buffer clear, and force the data toggle or clear the split status by writing ones.

The transaction engine asks for a handshake by asserting `txn_query` with a pipe index and a direction. In the same cycle the block returns the handshake code, the expected DATA0/DATA1 PID and, where it applies, a not-ready pulse. When the transaction ends, the engine reports the result on `txn_done`. The block then updates the pipe's toggle, busy and split state.

The per-pipe buffer state comes in on two vectors: whether buffer access is allowed, and whether transmittable data is present. Register reads are combinational on `reg_addr`.

Top module: `usb_pipe_resp`

## Requirements
- R1: Pipe p (0-based) has its control word at byte address 70h+2p. The layout is: bits 1:0 response code (RW), bit 2 toggle monitor (R), bit 3 busy (R), bit 4 toggle-clear strobe (W1), bit 5 toggle-set strobe (W1), bit 6 auto-response enable (RW), bit 7 auto-buffer-clear (RW), bit 8 split-clear strobe (W1), bit 9 split status (R), bit 10 buffer access (R), bit 11 transmit data present (R). Unassigned bits and strobe bits read 0. Any other address reads 0, and writes to it change nothing.
- R2: `hs_code` is 00 ACK/data, 01 NAK, 10 STALL, 11 zero-length packet. A response code of 00 gives NAK. A response code of 10 or 11 gives STALL. An out-of-range pipe index gives NAK.
- R3: With response code 01 and auto-response off, the handshake follows the buffer. On transmit (`txn_tx`=1) it is ACK/data if `buf_data[p]` is set, else NAK. On receive it is ACK if `buf_access[p]` is set, else NAK.
- R4: With response code 01 and auto-response on, the buffer state is ignored. Transmit gives a zero-length packet. Receive gives NAK, and `nrdy` is high during the query.
- R5: Writing 1 to the toggle-clear bit sets the toggle to DATA0. Writing 1 to the toggle-set bit sets it to DATA1. If both are 1, clear wins. Zeros in these bits leave the toggle unchanged.
- R6: A `txn_done` with result 00 (ACK) inverts the pipe's toggle. Results 01 NAK, 10 STALL and 11 error leave it unchanged. A toggle strobe written in the same cycle overrides the inversion.
- R7: `exp_pid` equals the queried pipe's toggle (0 DATA0, 1 DATA1). The toggle monitor bit reads the same value.
- R8: The busy bit is set by a query to the pipe and cleared by a `txn_done` for it.
- R9: The split status is loaded from `txn_csplit` at `txn_done`. Writing 1 to the split-clear bit clears it, and the clear wins over a same-cycle load.
- R10: The buffer access and data-present bits read the live `buf_access[p]` and `buf_data[p]` inputs.
- R11: `buf_clr[p]` pulses in the write cycle that takes auto-buffer-clear from 0 to 1.
- R12: After reset every pipe reads all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| buf_access | input | 5 | Per-pipe buffer access allowed |
| buf_data | input | 5 | Per-pipe transmittable data present |
| txn_query | input | 1 | Handshake request for `txn_pipe` |
| txn_done | input | 1 | Transaction finished for `txn_pipe` |
| txn_pipe | input | 3 | Pipe index |
| txn_tx | input | 1 | 1 transmit, 0 receive |
| txn_result | input | 2 | 00 ACK, 01 NAK, 10 STALL, 11 error |
| txn_csplit | input | 1 | Pipe enters complete-split phase |
| hs_code | output | 2 | Handshake to send |
| exp_pid | output | 1 | Expected data PID |
| nrdy | output | 1 | Not-ready interrupt pulse |
| buf_clr | output | 5 | Per-pipe buffer clear pulse |

## Verification
Four behaviours are checked on every clock: an ACK completion with no concurrent write flips exactly one toggle, the toggles hold when nothing acts on them, a query leaves the pipe busy, and `nrdy` only comes with a receive-side NAK. The handshake ladder across the response codes and the auto mode can only be shown by the bench's scenarios. The same goes for the override order of the strobes against completions and the readback of every field, which the bench covers with random traffic and a reference model.

// File: rtl/usb_pipe_resp.sv
module usb_pipe_resp #(
  parameter int NP   = 5,
  parameter int AW   = 8,
  parameter int BASE = 'h70,
  localparam int PW  = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic [NP-1:0] buf_access,
  input  logic [NP-1:0] buf_data,
  input  logic          txn_query,
  input  logic          txn_done,
  input  logic [PW-1:0] txn_pipe,
  input  logic          txn_tx,
  input  logic [1:0]    txn_result,
  input  logic          txn_csplit,
  output logic [1:0]    hs_code,
  output logic          exp_pid,
  output logic          nrdy,
  output logic [NP-1:0] buf_clr
);
  localparam logic [1:0] HS_ACK = 2'b00, HS_NAK = 2'b01, HS_STALL = 2'b10, HS_ZLP = 2'b11;

  logic [1:0]    resp_q [NP];
  logic [NP-1:0] auto_q, aclr_q, tog_q, busy_q, split_q;
  logic [15:0]   word   [NP];

  wire           sel_ok = txn_pipe < PW'(NP);
  wire [PW-1:0]  idx    = sel_ok ? txn_pipe : '0;

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    localparam logic [AW-1:0] ADDR = AW'(BASE + 2 * p);
    wire hit   = reg_we && reg_addr == ADDR;
    wire mine  = txn_pipe == PW'(p);
    wire fin   = txn_done && mine;
    wire ask   = txn_query && mine;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        resp_q[p]  <= 2'b00;
        auto_q[p]  <= 1'b0;
        aclr_q[p]  <= 1'b0;
        tog_q[p]   <= 1'b0;
        busy_q[p]  <= 1'b0;
        split_q[p] <= 1'b0;
      end else begin
        if (hit) begin
          resp_q[p] <= reg_wdata[1:0];
          auto_q[p] <= reg_wdata[6];
          aclr_q[p] <= reg_wdata[7];
        end
        if (hit && reg_wdata[4])      tog_q[p] <= 1'b0;
        else if (hit && reg_wdata[5]) tog_q[p] <= 1'b1;
        else if (fin && txn_result == 2'b00) tog_q[p] <= ~tog_q[p];
        if (ask)      busy_q[p] <= 1'b1;
        else if (fin) busy_q[p] <= 1'b0;
        if (hit && reg_wdata[8]) split_q[p] <= 1'b0;
        else if (fin)            split_q[p] <= txn_csplit;
      end
    end

    assign word[p] = {4'b0, buf_data[p], buf_access[p], split_q[p], 1'b0,
                      aclr_q[p], auto_q[p], 2'b00, busy_q[p], tog_q[p], resp_q[p]};
    assign buf_clr[p] = hit && reg_wdata[7] && !aclr_q[p];
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NP; p++)
      if (reg_addr == AW'(BASE + 2 * p)) reg_rdata = word[p];
  end

  always_comb begin
    nrdy    = 1'b0;
    hs_code = HS_NAK;
    if (!sel_ok)                hs_code = HS_NAK;
    else if (resp_q[idx][1])    hs_code = HS_STALL;
    else if (!resp_q[idx][0])   hs_code = HS_NAK;
    else if (auto_q[idx]) begin
      if (txn_tx) hs_code = HS_ZLP;
      else begin
        hs_code = HS_NAK;
        nrdy    = txn_query;
      end
    end else if (txn_tx)        hs_code = buf_data[idx]   ? HS_ACK : HS_NAK;
    else                        hs_code = buf_access[idx] ? HS_ACK : HS_NAK;
  end

  assign exp_pid = sel_ok && tog_q[idx];
endmodule

module usb_pipe_resp_chk #(
  parameter int NP = 5,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          txn_query,
  input logic          txn_done,
  input logic          txn_tx,
  input logic [PW-1:0] txn_pipe,
  input logic [1:0]    txn_result,
  input logic [1:0]    hs_code,
  input logic          nrdy,
  input logic [NP-1:0] tog_q,
  input logic [NP-1:0] busy_q
);
  logic [NP-1:0] qoh;
  assign qoh = (txn_pipe < PW'(NP)) ? NP'(1) << txn_pipe : '0;

  // R6
  ack_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && txn_result == 2'b00 && qoh != '0 && !reg_we) |=> $countones(tog_q ^ $past(tog_q)) == 1);
  // R6
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !(txn_done && txn_result == 2'b00)) |=> $stable(tog_q));
  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_query |=> ((busy_q & $past(qoh)) == $past(qoh)));
  // R4
  nrdy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrdy |-> (hs_code == 2'b01 && !txn_tx && txn_query));
endmodule

bind usb_pipe_resp usb_pipe_resp_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .txn_query(txn_query), .txn_done(txn_done),
  .txn_tx(txn_tx), .txn_pipe(txn_pipe), .txn_result(txn_result), .hs_code(hs_code),
  .nrdy(nrdy), .tog_q(tog_q), .busy_q(busy_q));

// File: tb/usb_pipe_resp_tb.sv
module usb_pipe_resp_tb;
  localparam int NP = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 0, txn_query = 0, txn_done = 0, txn_tx = 0, txn_csplit = 0;
  logic [7:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [4:0]  buf_access = 0, buf_data = 0, buf_clr;
  logic [2:0]  txn_pipe = 0;
  logic [1:0]  txn_result = 0, hs_code;
  logic        exp_pid, nrdy;

  usb_pipe_resp u_dut (.*);

  logic [1:0] m_resp [NP];
  logic [NP-1:0] m_auto = 0, m_aclr = 0, m_tog = 0, m_busy = 0, m_split = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [7:0] paddr(int p); return 8'(8'h70 + 2 * p); endfunction

  function automatic logic [15:0] exp_rd(logic [7:0] a);
    for (int p = 0; p < NP; p++)
      if (a == paddr(p))
        return {4'b0, buf_data[p], buf_access[p], m_split[p], 1'b0, m_aclr[p], m_auto[p],
                2'b00, m_busy[p], m_tog[p], m_resp[p]};
    return 16'h0;
  endfunction

  function automatic logic [2:0] exp_hs(int p, logic tx, logic q);
    if (p >= NP)          return 3'b001;
    if (m_resp[p][1])     return 3'b010;
    if (!m_resp[p][0])    return 3'b001;
    if (m_auto[p])        return tx ? 3'b011 : {q, 2'b01};
    if (tx)               return buf_data[p] ? 3'b000 : 3'b001;
    return buf_access[p] ? 3'b000 : 3'b001;
  endfunction

  function automatic string hs_tag(int p);
    if (p >= NP || m_resp[p] != 2'b01) return "R2";
    return m_auto[p] ? "R4" : "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [7:0] a, logic [15:0] wd, logic q, logic d,
                      int p, logic tx, logic [1:0] res, logic cs);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; txn_query = q; txn_done = d;
    txn_pipe = 3'(p); txn_tx = tx; txn_result = res; txn_csplit = cs;
    #1;
    chk(tag, reg_rdata, exp_rd(a));
    if (q) begin
      chk(hs_tag(p), {nrdy, hs_code}, exp_hs(p, tx, 1'b1));
      chk("R7", exp_pid, (p < NP) ? m_tog[p] : 1'b0);
    end
    begin
      logic [4:0] ec = 0;
      for (int k = 0; k < NP; k++) if (we && a == paddr(k) && wd[7] && !m_aclr[k]) ec[k] = 1;
      chk("R11", buf_clr, ec);
    end
    @(posedge clk);
    if (p < NP) begin
      if (d) begin
        if (res == 2'b00) m_tog[p] = ~m_tog[p];
        m_busy[p] = 1'b0;
        m_split[p] = cs;
      end
      if (q) m_busy[p] = 1'b1;
    end
    for (int k = 0; k < NP; k++)
      if (we && a == paddr(k)) begin
        m_resp[k] = wd[1:0]; m_auto[k] = wd[6]; m_aclr[k] = wd[7];
        if (wd[4]) m_tog[k] = 1'b0; else if (wd[5]) m_tog[k] = 1'b1;
        if (wd[8]) m_split[k] = 1'b0;
      end
  endtask

  task automatic rd(string tag, int p);
    step(tag, 0, paddr(p), 0, 0, 0, 7, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NP; k++) m_resp[k] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    for (int k = 0; k < NP; k++) rd("R12", k);
    // R1 unused address and unassigned bits
    step("R1", 1, 8'h71, 16'hFFFF, 0, 0, 7, 0, 0, 0);
    step("R1", 1, 8'h7A, 16'hFFFF, 0, 0, 7, 0, 0, 0);
    rd("R1", 0); rd("R1", 4);
    // R5 set, then both strobes (clear wins), then zero strobes
    step("R5", 1, paddr(1), 16'h0021, 0, 0, 7, 0, 0, 0);
    rd("R5", 1);
    step("R5", 1, paddr(1), 16'h0031, 0, 0, 7, 0, 0, 0);
    rd("R5", 1);
    step("R5", 1, paddr(1), 16'h0021, 0, 0, 7, 0, 0, 0);
    step("R5", 1, paddr(1), 16'h0001, 0, 0, 7, 0, 0, 0);
    rd("R5", 1);
    // R6 ACK flips, NAK/STALL/error keep, strobe beats ACK
    step("R6", 0, paddr(2), 0, 0, 1, 2, 0, 2'b00, 0);
    rd("R6", 2);
    step("R6", 0, paddr(2), 0, 0, 1, 2, 0, 2'b01, 0);
    step("R6", 0, paddr(2), 0, 0, 1, 2, 0, 2'b11, 0);
    rd("R6", 2);
    step("R6", 1, paddr(2), 16'h0020, 0, 1, 2, 0, 2'b00, 0);
    rd("R6", 2);
    // R8 busy, R2 stall
    step("R8", 1, paddr(3), 16'h0002, 0, 0, 7, 0, 0, 0);
    step("R2", 0, paddr(3), 0, 1, 0, 3, 1, 0, 0);
    rd("R8", 3);
    step("R8", 0, paddr(3), 0, 0, 1, 3, 0, 2'b10, 0);
    rd("R8", 3);
    // R9 split load, then clear wins over load
    step("R9", 0, paddr(0), 0, 0, 1, 0, 0, 2'b01, 1);
    rd("R9", 0);
    step("R9", 1, paddr(0), 16'h0100, 0, 1, 0, 0, 2'b01, 1);
    rd("R9", 0);
    // R4 auto response, R10 buffer readback, R11 clear pulse
    buf_access = 5'h1F; buf_data = 5'h1F;
    step("R11", 1, paddr(4), 16'h00C1, 0, 0, 7, 0, 0, 0);
    step("R10", 0, paddr(4), 0, 1, 0, 4, 1, 0, 0);
    step("R4", 0, paddr(4), 0, 1, 0, 4, 0, 0, 0);
    step("R11", 1, paddr(4), 16'h0081, 0, 0, 7, 0, 0, 0);
    // R3 buffer-driven, plus random traffic
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 4;
      int p = $urandom % 6;
      logic [15:0] wd = 16'($urandom);
      buf_access = 5'($urandom); buf_data = 5'($urandom);
      if (($urandom % 3) != 0) wd[8:4] = '0;
      if (($urandom % 2) != 0) wd[1:0] = 2'b01;
      case (op)
        0: step("R1", 1, (p < NP) ? paddr(p) : 8'(8'h60 + $urandom % 64), wd, 0, 0, 7, 0, 0, 0);
        1: step("R3", 0, paddr($urandom % NP), 0, 1, 0, p, 1'($urandom), 0, 0);
        2: step("R6", 0, paddr($urandom % NP), 0, 0, 1, p, 0, 2'($urandom), 1'($urandom));
        default: step("R10", 0, paddr(p % NP), 0, 0, 0, 7, 0, 0, 0);
      endcase
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule